// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block is a fully associative translation buffer. It holds 32 mappings from virtual page numbers to physical page numbers. Each entry has its own page size, chosen from four sizes between 4 KB and 8 MB. Because the size belongs to the entry, the number of virtual-address bits taken into the tag compare differs from entry to entry. Each entry also carries a 4-bit address-space tag, a shared flag, a lock flag and a 4-bit protection-group index.

A lookup presents a 32-bit virtual address, the current address-space tag and a read/write flag. One cycle later the block returns hit, the translated physical address and a protection-fault flag. The fault flag comes from a 16-entry array of 2-bit permission fields, one field per protection group.

Software can fill entries in two ways: at an explicit index, or at an index chosen by a round-robin pointer that steps past locked entries. A single flush input invalidates every entry.

Top module: `tlb_multisize`

## Requirements
- R1: A lookup presented with `lk_valid` high produces `rsp_valid` high exactly one clock later. With `lk_valid` low, `rsp_valid` is low one clock later.
- R2: Field `wr_size` gives the page size: 0 = 4 KB, 1 = 16 KB, 2 = 512 KB, 3 = 8 MB. The low 12, 14, 19 or 23 address bits are left out of the compare. On a hit, those bits of the virtual address pass unchanged into the physical address, and the remaining upper bits come from the entry's physical page.
- R3: An entry matches only if its address-space tag equals `lk_asid`, unless the entry was loaded with `wr_global` set. A global entry matches under any address-space tag.
- R4: When several valid entries match one lookup, the lowest-numbered entry supplies the result.
- R5: The permission field of the entry's group is read as follows: 00 = no access, 01 = read-only, 10 or 11 = read/write. A hit raises `rsp_fault` when the field is 00, or when the field is 01 and `lk_write` is 1.
- R6: A lookup that matches no valid entry returns `rsp_hit`=0, `rsp_fault`=0 and `rsp_paddr`=0.
- R7: With `wr_en`=1 and `wr_any`=0, the entry at `wr_index` is overwritten and becomes valid.
- R8: With `wr_en`=1 and `wr_any`=1, the entry written is the first one, searching upward from the round-robin pointer with wrap-around, that is not both valid and locked. The pointer then moves to the entry after it. If every entry is valid and locked, the write is dropped and the pointer stays where it is.
- R9: `flush` clears every entry's valid and lock bits and returns the pointer to 0. A write presented in the same cycle as `flush` is dropped.
- R10: After reset no entry is valid, every permission field is 00 and the pointer is 0. `perm_we` writes `perm_val` into field `perm_idx`.
- R11: A lookup made in the same cycle as an entry write or a permission write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 4 | Current address-space tag |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| wr_en | input | 1 | Entry write strobe |
| wr_any | input | 1 | 1 = round-robin victim, 0 = use wr_index |
| wr_index | input | 5 | Explicit entry index |
| wr_vpn | input | 20 | Virtual address bits 31:12 |
| wr_ppn | input | 20 | Physical address bits 31:12 |
| wr_size | input | 2 | Page size code |
| wr_asid | input | 4 | Entry address-space tag |
| wr_group | input | 4 | Protection-group index |
| wr_global | input | 1 | Match under any address-space tag |
| wr_lock | input | 1 | Exclude the entry from round-robin replacement |
| perm_we | input | 1 | Permission field write strobe |
| perm_idx | input | 4 | Permission field index |
| perm_val | input | 2 | Permission value |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_paddr | output | 32 | Translated address |
| rsp_fault | output | 1 | Access not permitted |

## Verification
Every response is due on the clock edge that follows its request: hit, address and fault are registered once and have no further pipeline stage. The effect of a write, a permission update or a flush is due on the first lookup issued in a later cycle. The bench drives each operation on a falling edge. Its reference model predicts the response from its state before that operation's updates, then compares all four outputs on the next falling edge, so each expectation is sampled exactly one register stage after its stimulus, and same-cycle write/lookup ordering is checked as part of that comparison.

// File: rtl/tlb_multisize.sv
module tlb_multisize #(
  parameter int ENTRIES = 32,
  parameter int GROUPS  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        lk_valid,
  input  logic [31:0] lk_vaddr,
  input  logic [3:0]  lk_asid,
  input  logic        lk_write,
  input  logic        wr_en,
  input  logic        wr_any,
  input  logic [4:0]  wr_index,
  input  logic [19:0] wr_vpn,
  input  logic [19:0] wr_ppn,
  input  logic [1:0]  wr_size,
  input  logic [3:0]  wr_asid,
  input  logic [3:0]  wr_group,
  input  logic        wr_global,
  input  logic        wr_lock,
  input  logic        perm_we,
  input  logic [3:0]  perm_idx,
  input  logic [1:0]  perm_val,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] e_v, e_lk, e_g;
  logic [19:0]        e_vpn [ENTRIES];
  logic [19:0]        e_ppn [ENTRIES];
  logic [1:0]         e_sz  [ENTRIES];
  logic [3:0]         e_as  [ENTRIES];
  logic [3:0]         e_grp [ENTRIES];
  logic [1:0]         perm  [GROUPS];
  logic [IW-1:0]      rr_ptr;

  function automatic logic [31:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'hFFFF_F000;
      2'd1:    return 32'hFFFF_C000;
      2'd2:    return 32'hFFF8_0000;
      default: return 32'hFF80_0000;
    endcase
  endfunction

  logic [ENTRIES-1:0] match;
  logic [IW-1:0]      sel;
  logic               any_hit;
  logic [31:0]        sel_mask, hit_paddr;
  logic [1:0]         sel_perm;
  logic               hit_fault;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      match[i] = e_v[i] && (e_g[i] || e_as[i] == lk_asid) &&
                 (((lk_vaddr ^ {e_vpn[i], 12'h000}) & page_mask(e_sz[i])) == 32'h0);
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IW'(i);
  end

  assign any_hit   = |match;
  assign sel_mask  = page_mask(e_sz[sel]);
  assign hit_paddr = ({e_ppn[sel], 12'h000} & sel_mask) | (lk_vaddr & ~sel_mask);
  assign sel_perm  = perm[e_grp[sel]];
  assign hit_fault = (sel_perm == 2'b00) || (sel_perm == 2'b01 && lk_write);

  logic [IW-1:0] rr_idx;
  logic          rr_found;
  always_comb begin
    rr_idx   = rr_ptr;
    rr_found = 1'b0;
    for (int k = 0; k < ENTRIES; k++) begin
      logic [IW-1:0] c;
      c = rr_ptr + IW'(k);
      if (!rr_found && !(e_v[c] && e_lk[c])) begin
        rr_idx   = c;
        rr_found = 1'b1;
      end
    end
  end

  logic [IW-1:0] tgt;
  logic          do_wr;
  assign tgt   = wr_any ? rr_idx : wr_index[IW-1:0];
  assign do_wr = wr_en && !flush && (!wr_any || rr_found);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v    <= '0;
      e_lk   <= '0;
      rr_ptr <= '0;
    end else if (flush) begin
      e_v    <= '0;
      e_lk   <= '0;
      rr_ptr <= '0;
    end else if (do_wr) begin
      e_v[tgt]  <= 1'b1;
      e_lk[tgt] <= wr_lock;
      if (wr_any) rr_ptr <= rr_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      e_vpn[tgt] <= wr_vpn;
      e_ppn[tgt] <= wr_ppn;
      e_sz[tgt]  <= wr_size;
      e_as[tgt]  <= wr_asid;
      e_grp[tgt] <= wr_group;
      e_g[tgt]   <= wr_global;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < GROUPS; g++) perm[g] <= 2'b00;
    end else if (perm_we) begin
      perm[perm_idx] <= perm_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_hit;
      rsp_paddr <= (lk_valid && any_hit) ? hit_paddr : 32'h0;
      rsp_fault <= lk_valid && any_hit && hit_fault;
    end
  end
endmodule

module tlb_multisize_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        lk_valid,
  input logic [31:0] lk_vaddr,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [31:0] rsp_paddr,
  input logic        rsp_fault
);
  assert_req_to_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_idle_no_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[11:0] == $past(lk_vaddr[11:0]));
  assert_miss_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_fault && rsp_paddr == 32'h0));
  assert_fault_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_hit && rsp_valid));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush, 2) && $past(lk_valid)) |-> !rsp_hit);
endmodule

bind tlb_multisize tlb_multisize_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/tb_tlb_multisize.sv
module tb_tlb_multisize;
  logic clk = 0, rst_n = 0;
  logic flush = 0, lk_valid = 0, lk_write = 0;
  logic [31:0] lk_vaddr = 0;
  logic [3:0] lk_asid = 0;
  logic wr_en = 0, wr_any = 0, wr_global = 0, wr_lock = 0;
  logic [4:0] wr_index = 0;
  logic [19:0] wr_vpn = 0, wr_ppn = 0;
  logic [1:0] wr_size = 0;
  logic [3:0] wr_asid = 0, wr_group = 0;
  logic perm_we = 0;
  logic [3:0] perm_idx = 0;
  logic [1:0] perm_val = 0;
  logic rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;

  always #5 clk = ~clk;

  tlb_multisize dut (.*);

  int checks = 0, errors = 0;
  string tag = "R1";

  bit m_v[32], m_l[32], m_g[32];
  int unsigned m_vpn[32], m_ppn[32], m_sz[32], m_as[32], m_grp[32];
  int unsigned m_perm[16];
  int m_ptr = 0;

  function automatic int unsigned shift_of(int unsigned s);
    int unsigned t[4] = '{12, 14, 19, 23};
    return t[s];
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic step();
    bit e_val, e_hit, e_flt;
    logic [31:0] e_pa;
    e_val = lk_valid; e_hit = 0; e_flt = 0; e_pa = 0;
    if (lk_valid) begin
      for (int i = 0; i < 32; i++) begin
        int unsigned sh;
        logic [31:0] m;
        sh = shift_of(m_sz[i]);
        m = 32'hFFFF_FFFF << sh;
        if (!e_hit && m_v[i] && (m_g[i] || m_as[i] == lk_asid) &&
            ((lk_vaddr & m) == ((m_vpn[i] << 12) & m))) begin
          int unsigned p;
          e_hit = 1;
          e_pa = ((m_ppn[i] << 12) & m) | (lk_vaddr & ~m);
          p = m_perm[m_grp[i]];
          e_flt = (p == 0) || (p == 1 && lk_write);
        end
      end
    end
    if (perm_we) m_perm[perm_idx] = perm_val;
    if (flush) begin
      for (int i = 0; i < 32; i++) begin m_v[i] = 0; m_l[i] = 0; end
      m_ptr = 0;
    end else if (wr_en) begin
      int t = -1;
      if (!wr_any) t = wr_index;
      else
        for (int k = 0; k < 32; k++) begin
          int c = (m_ptr + k) % 32;
          if (t < 0 && !(m_v[c] && m_l[c])) t = c;
        end
      if (t >= 0) begin
        m_v[t] = 1; m_l[t] = wr_lock; m_g[t] = wr_global;
        m_vpn[t] = wr_vpn; m_ppn[t] = wr_ppn; m_sz[t] = wr_size;
        m_as[t] = wr_asid; m_grp[t] = wr_group;
        if (wr_any) m_ptr = (t + 1) % 32;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, rsp_valid, e_val, "rsp_valid");
    if (e_val) begin
      check(tag, rsp_hit, e_hit, "rsp_hit");
      check(tag, rsp_paddr, e_pa, "rsp_paddr");
      check(tag, rsp_fault, e_flt, "rsp_fault");
    end
    flush = 0; lk_valid = 0; lk_write = 0; wr_en = 0; wr_any = 0; perm_we = 0;
    wr_lock = 0; wr_global = 0;
  endtask

  task automatic look(logic [31:0] va, logic [3:0] as, bit w);
    lk_valid = 1; lk_vaddr = va; lk_asid = as; lk_write = w;
    step();
  endtask

  task automatic load(bit any, int idx, int vpn, int ppn, int sz, int as, int grp, bit g, bit lk);
    wr_en = 1; wr_any = any; wr_index = 5'(idx); wr_vpn = 20'(vpn); wr_ppn = 20'(ppn);
    wr_size = 2'(sz); wr_asid = 4'(as); wr_group = 4'(grp); wr_global = g; wr_lock = lk;
    step();
  endtask

  task automatic setperm(int g, int v);
    perm_we = 1; perm_idx = 4'(g); perm_val = 2'(v);
    step();
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 16; g++) m_perm[g] = 0;
    for (int i = 0; i < 32; i++) begin m_v[i] = 0; m_l[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R10"; step(); look(32'h1234_5678, 0, 0);
    look(32'h0000_0000, 5, 1);
    tag = "R10"; setperm(1, 2); setperm(2, 1); setperm(3, 0); setperm(4, 3);
    tag = "R7"; load(0, 5, 'h12345, 'hABCDE, 0, 3, 1, 0, 0);
    tag = "R2"; look(32'h1234_5678, 3, 0);
    tag = "R7"; load(0, 6, 'h40000, 'h80003, 1, 3, 4, 0, 0);
    tag = "R2"; look(32'h4000_3ABC, 3, 1);
    look(32'h4000_4ABC, 3, 0);
    tag = "R7"; load(0, 7, 'h00200, 'h33333, 2, 3, 1, 0, 0);
    tag = "R2"; look(32'h0027_FFFF, 3, 0); look(32'h0028_0000, 3, 0);
    tag = "R7"; load(0, 8, 'hF0000, 'h01234, 3, 9, 2, 1, 0);
    tag = "R2"; look(32'hF07F_FFFC, 9, 0); look(32'hF080_0000, 9, 0);
    tag = "R3"; look(32'h1234_5000, 4, 0); look(32'hF012_3456, 0, 0); look(32'hF012_3456, 15, 0);
    tag = "R5"; look(32'hF000_0010, 1, 1); look(32'hF000_0010, 1, 0);
    load(0, 10, 'h77777, 'h11111, 0, 2, 3, 0, 0);
    look(32'h7777_7004, 2, 0); look(32'h4000_0000, 3, 1); look(32'h1234_5000, 3, 1);
    tag = "R4"; load(0, 2, 'h55555, 'h22222, 0, 1, 1, 0, 0);
    load(0, 9, 'h55555, 'h99999, 0, 1, 1, 0, 0);
    look(32'h5555_5123, 1, 0);
    load(0, 1, 'h55554, 'h66666, 1, 1, 1, 0, 0);
    look(32'h5555_5123, 1, 0);
    tag = "R11"; lk_valid = 1; lk_vaddr = 32'h3333_3000; lk_asid = 1;
    load(0, 11, 'h33333, 'h44444, 0, 1, 1, 0, 0);
    look(32'h3333_3000, 1, 0);
    lk_valid = 1; lk_vaddr = 32'h3333_3000; lk_asid = 1; lk_write = 1;
    setperm(1, 1);
    look(32'h3333_3000, 1, 1);
    tag = "R9"; flush = 1; step(); look(32'h3333_3000, 1, 0);
    flush = 1; wr_en = 1; wr_index = 3; wr_vpn = 'h00001; step();
    look(32'h0000_1000, 0, 0);
    tag = "R8"; load(0, 0, 'h00010, 'h00100, 0, 0, 4, 0, 1);
    load(0, 1, 'h00011, 'h00101, 0, 0, 4, 0, 1);
    load(1, 0, 'h00012, 'h00102, 0, 0, 4, 0, 0);
    for (int k = 0; k < 34; k++) load(1, 0, 'h00100 + k, 'h00200 + k, 0, 0, 4, 0, k % 5 == 0);
    for (int k = 0; k < 40; k++) look(32'h0001_0000 + (k << 12), 0, 0);
    look(32'h0001_2000, 0, 0);
    flush = 1; step();
    for (int i = 0; i < 32; i++) load(0, i, 'h00500 + i, 'h00600 + i, 0, 0, 4, 0, 1);
    load(1, 0, 'h00999, 'h00888, 0, 0, 4, 0, 0);
    look(32'h0099_9000, 0, 0); look(32'h0050_0000, 0, 0); look(32'h0051_F000, 0, 0);
    tag = "R1"; flush = 1; step();
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 5) flush = ($urandom_range(0, 9) == 0);
      if (r < 30) begin
        wr_en = 1; wr_any = $urandom_range(0, 1); wr_index = 5'($urandom);
        wr_vpn = 20'($urandom_range(0, 63)) << ($urandom_range(0, 3) * 3);
        wr_ppn = 20'($urandom); wr_size = 2'($urandom);
        wr_asid = 4'($urandom_range(0, 3)); wr_group = 4'($urandom);
        wr_global = ($urandom_range(0, 7) == 0); wr_lock = ($urandom_range(0, 3) == 0);
      end
      if (r >= 90) begin perm_we = 1; perm_idx = 4'($urandom); perm_val = 2'($urandom); end
      if ($urandom_range(0, 2) != 0) begin
        lk_valid = 1;
        lk_vaddr = (32'($urandom_range(0, 63)) << (12 + $urandom_range(0, 3) * 3)) ^ 32'($urandom_range(0, 4095));
        lk_asid = 4'($urandom_range(0, 3)); lk_write = $urandom_range(0, 1);
      end
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule